// File: doc/BRIEF.md
# Cartridge Bus Access Decoder

This block lives on the cartridge side of a console expansion bus. The bus has 20 address lines, a 16-bit data bus, active-low read, write and select strobes, and a line that marks each cycle as a memory access or an I/O port access. The block looks at each cycle and decides whether the cartridge owns it. It then drives chip enables, an output enable and a write enable for an external SRAM and an external ROM. It also tells the cartridge's data-bus drivers which byte lanes to turn on.

The address decode is purely combinational. The console holds the address steady before a strobe falls, and the whole decode has to settle within about 162 ns of strobe-low time. The I/O port writes work differently. The write strobe passes through a synchronizer clocked by a fast internal clock. Once the synchronized strobe rises, a one-cycle register-write pulse goes out with the port number and data word that were captured while the strobe was low.

The memory map is split by the top address nibble. Segment 0x0 belongs to the console, segment 0x1 is SRAM, and segments 0x2 to 0xF are ROM. SRAM cycles are always byte wide. ROM cycles are 16 bits wide when the width configuration input is set.

Top module: `cart_bus_decoder`

## Requirements
- R1: In a memory cycle (`mem_sel`=1) with `sel_n`=0, the segment `bus_addr[19:16]` selects the target. Segment 0 enables nothing, segment 1 pulls `sram_ce_n` low, and segments 2 to 15 pull `rom_ce_n` low. Both enables stay high when `sel_n`=1, and the two are never low together.
- R2: `mem_oe_n` is low exactly when a claimed memory cycle has `sel_n`=0 and `rd_n`=0. `mem_we_n` is low exactly when a claimed memory cycle has `sel_n`=0 and `wr_n`=0.
- R3: A ROM cycle with `rom_wide`=1 is a 16-bit cycle. In such a cycle `dev_addr[0]` is forced to 0 and `drive_hi` follows `drive_lo`. SRAM cycles, I/O cycles and ROM cycles with `rom_wide`=0 never assert `drive_hi`.
- R4: `dev_addr[19:1]` always equals `bus_addr[19:1]`. In any cycle that is not 16-bit, `dev_addr[0]` equals `bus_addr[0]`.
- R5: In an I/O cycle (`mem_sel`=0), the port is `bus_addr[7:0]`. Only ports 0xC0 to 0xFF with a well-formed mirror are claimed. No memory enable or memory strobe is asserted in an I/O cycle.
- R6: An I/O cycle is malformed if `bus_addr[15:8]` is nonzero or if `bus_addr[19:16]` differs from port bits 7:4. A malformed cycle is never claimed, and `io_malformed` is 1 while `sel_n`=0. `io_malformed` is 0 in all other cases.
- R7: `drive_lo` is 1 only when `sel_n`=0, `rd_n`=0 and the cycle is claimed.
- R8: A claimed I/O write produces exactly one `io_wr_pulse` cycle within 8 internal clocks after `wr_n` rises. At that pulse, `io_wr_port` and `io_wr_data` hold the port and the full 16-bit data word that were present while `wr_n` was low.
- R9: An I/O write to an unclaimed port, a malformed I/O write, or a write while `sel_n`=1 produces no `io_wr_pulse`.
- R10: After reset, `io_wr_pulse`, `io_wr_port` and `io_wr_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 20 | Console address lines |
| bus_data | input | 16 | Console data lines as seen by the cartridge |
| mem_sel | input | 1 | 1 = memory cycle, 0 = I/O port cycle |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| sel_n | input | 1 | Cartridge select, active low |
| rom_wide | input | 1 | ROM cycles are 16-bit when 1 |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| dev_addr | output | 20 | Address presented to the memory devices |
| drive_lo | output | 1 | Enable cartridge drivers on data bits 7:0 |
| drive_hi | output | 1 | Enable cartridge drivers on data bits 15:8 |
| io_malformed | output | 1 | Selected I/O cycle with a bad address mirror |
| io_wr_pulse | output | 1 | One-clock internal port write strobe |
| io_wr_port | output | 8 | Captured port number |
| io_wr_data | output | 16 | Captured write data |

## Verification
The memory decode is swept over all sixteen segments with both width settings, both values of A0, idle, read and write strobes, and select on and off. This separates the console-owned segment from SRAM and ROM, and byte cycles from 16-bit cycles. The I/O decode is swept over all 256 port numbers. Each port is tried with a correct mirror, with a corrupted middle byte and with a corrupted top nibble, which tells claimed, unclaimed and malformed cycles apart. Port writes go through the synchronizer for boundary ports (0xBF, 0xC0, 0xFF), a mid-range port, a malformed cycle and a deselected cycle. Each write checks the pulse count, the captured port and the captured data.

// File: rtl/cbd_pkg.sv
// Shared types for the cartridge bus access decoder.
package cbd_pkg;
    // Who owns the current bus cycle.
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_SRAM = 2'd1,
        TGT_ROM  = 2'd2,
        TGT_PORT = 2'd3
    } tgt_e;

    // Result of the combinational address decode.
    typedef struct packed {
        tgt_e tgt;        // owning target
        logic malformed;  // I/O mirror mismatch
        logic wide;       // 16-bit cycle
    } dec_s;
endpackage

// File: rtl/cbd_addr_decode.sv
// Combinational classifier for one bus cycle.
// Assumes: the address is stable before any strobe falls. The segment is the top
// SEG_W address bits. During I/O cycles the bits between the port and the
// segment are zero, and the segment repeats the high port bits.
module cbd_addr_decode
    import cbd_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int SEG_W      = 4,
    parameter int PORT_W     = 8,
    parameter int SRAM_SEG   = 1,
    parameter int ROM_SEG_LO = 2,
    parameter int PORT_LO    = 'hC0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_sel,
    input  logic              rom_wide,
    output dec_s              dec
);
    localparam int SEG_LSB = ADDR_W - SEG_W;
    localparam int MID_W   = SEG_LSB - PORT_W;

    logic [SEG_W-1:0]  seg;
    logic [PORT_W-1:0] port;
    logic [MID_W-1:0]  mid;
    logic              mirror_bad;

    // Split the address into its fields.
    always_comb begin
        seg  = addr[ADDR_W-1:SEG_LSB];
        port = addr[PORT_W-1:0];
        mid  = addr[SEG_LSB-1:PORT_W];
        mirror_bad = (mid != '0) || (seg != port[PORT_W-1:PORT_W-SEG_W]);
    end

    // Classify the cycle and decide its width.
    always_comb begin
        dec = '{tgt: TGT_NONE, malformed: 1'b0, wide: 1'b0};
        if (mem_sel) begin
            if (int'(seg) == SRAM_SEG) begin
                dec.tgt = TGT_SRAM;
            end else if (int'(seg) >= ROM_SEG_LO) begin
                dec.tgt  = TGT_ROM;
                dec.wide = rom_wide;
            end
        end else begin
            dec.malformed = mirror_bad;
            if (!mirror_bad && int'(port) >= PORT_LO) begin
                dec.tgt = TGT_PORT;
            end
        end
    end
endmodule

// File: rtl/cbd_strobe_sync.sv
// Multi-stage synchronizer with rising-edge detect for an asynchronous strobe.
// Assumes: the strobe stays at each level for longer than STAGES+1 clocks.
module cbd_strobe_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic rise
);
    logic [STAGES:0] sh;

    // Shift the raw strobe through the synchronizer and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= {(STAGES+1){RESET_VAL}};
        else        sh <= {sh[STAGES-1:0], d};
    end

    // Expose the synchronized level and its rising edge.
    always_comb begin
        q    = sh[STAGES-1];
        rise = sh[STAGES-1] & ~sh[STAGES];
    end
endmodule

// File: rtl/cbd_port_write.sv
// Captures a claimed I/O write while its strobe is low and issues one pulse
// after the synchronized strobe rises.
// Assumes: data is valid from the strobe's falling edge until it rises.
module cbd_port_write #(
    parameter int PORT_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              claim_now,
    input  logic [PORT_W-1:0] port_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              wr_rise,
    output logic              pulse,
    output logic [PORT_W-1:0] port_q,
    output logic [DATA_W-1:0] data_q
);
    logic armed;

    // Hold the latest port and data sampled during a claimed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
            data_q <= '0;
        end else if (claim_now) begin
            port_q <= port_in;
            data_q <= data_in;
        end
    end

    // Arm on a claimed write, fire once when the strobe edge arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            pulse <= 1'b0;
        end else begin
            pulse <= wr_rise & armed;
            if (claim_now)    armed <= 1'b1;
            else if (wr_rise) armed <= 1'b0;
        end
    end
endmodule

// File: rtl/cart_bus_decoder.sv
// Cartridge-side bus access decoder: memory enables, byte-lane drive enables
// and a synchronized I/O register write strobe.
// Assumes: strobes are asynchronous to clk and the address leads the strobes.
module cart_bus_decoder
    import cbd_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 16,
    parameter int SEG_W       = 4,
    parameter int PORT_W      = 8,
    parameter int SRAM_SEG    = 1,
    parameter int ROM_SEG_LO  = 2,
    parameter int PORT_LO     = 'hC0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              mem_sel,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              sel_n,
    input  logic              rom_wide,
    output logic              rom_ce_n,
    output logic              sram_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              drive_lo,
    output logic              drive_hi,
    output logic              io_malformed,
    output logic              io_wr_pulse,
    output logic [PORT_W-1:0] io_wr_port,
    output logic [DATA_W-1:0] io_wr_data
);
    dec_s dec;
    logic hit_mem;
    logic hit_port;
    logic claimed;
    logic wr_sync;
    logic wr_rise;
    logic port_claim_now;

    cbd_addr_decode #(
        .ADDR_W(ADDR_W), .SEG_W(SEG_W), .PORT_W(PORT_W),
        .SRAM_SEG(SRAM_SEG), .ROM_SEG_LO(ROM_SEG_LO), .PORT_LO(PORT_LO)
    ) u_dec (
        .addr(bus_addr), .mem_sel(mem_sel), .rom_wide(rom_wide), .dec(dec)
    );

    // Derive the memory enables and strobes from the decode.
    always_comb begin
        hit_mem   = (dec.tgt == TGT_SRAM) || (dec.tgt == TGT_ROM);
        hit_port  = (dec.tgt == TGT_PORT);
        claimed   = hit_mem || hit_port;
        rom_ce_n  = !(!sel_n && dec.tgt == TGT_ROM);
        sram_ce_n = !(!sel_n && dec.tgt == TGT_SRAM);
        mem_oe_n  = !(!sel_n && hit_mem && !rd_n);
        mem_we_n  = !(!sel_n && hit_mem && !wr_n);
        io_malformed = !sel_n && dec.malformed;
    end

    // Form the device address. A0 is zero in 16-bit cycles.
    always_comb begin
        dev_addr    = bus_addr;
        dev_addr[0] = bus_addr[0] & ~dec.wide;
    end

    // Turn on the byte-lane drivers only for selected, claimed reads.
    always_comb begin
        drive_lo = !sel_n && !rd_n && claimed;
        drive_hi = drive_lo && dec.wide;
    end

    cbd_strobe_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .d(wr_n), .q(wr_sync), .rise(wr_rise)
    );

    // Sample only while the raw strobe is low, before any edge is seen.
    always_comb port_claim_now = !sel_n && !wr_n && !wr_sync && hit_port;

    cbd_port_write #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_pwr (
        .clk(clk), .rst_n(rst_n), .claim_now(port_claim_now),
        .port_in(bus_addr[PORT_W-1:0]), .data_in(bus_data),
        .wr_rise(wr_rise), .pulse(io_wr_pulse),
        .port_q(io_wr_port), .data_q(io_wr_data)
    );
endmodule

// File: rtl/cbd_checker.sv
// Temporal checks on the decoder's ports, bound into every instance.
module cbd_checker #(
    parameter int PORT_W  = 8,
    parameter int PORT_LO = 'hC0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              rom_ce_n,
    input logic              sram_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              drive_lo,
    input logic              drive_hi,
    input logic              io_wr_pulse,
    input logic [PORT_W-1:0] io_wr_port
);
    assert_ce_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rom_ce_n && !sram_ce_n));
    assert_oe_needs_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!rd_n && !sel_n));
    assert_we_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!wr_n && !sel_n));
    assert_hi_lane_needs_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        drive_hi |-> drive_lo);
    assert_drive_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drive_lo |-> (!sel_n && !rd_n));
    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr_pulse |=> !io_wr_pulse);
    assert_pulse_port_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr_pulse |-> (int'(io_wr_port) >= PORT_LO));
endmodule

bind cart_bus_decoder cbd_checker #(.PORT_W(PORT_W), .PORT_LO(PORT_LO)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
    .rom_ce_n(rom_ce_n), .sram_ce_n(sram_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .drive_lo(drive_lo), .drive_hi(drive_hi),
    .io_wr_pulse(io_wr_pulse), .io_wr_port(io_wr_port)
);

// File: tb/tb_cart_bus_decoder.sv
module tb_cart_bus_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic        mem_sel = 1'b1, rd_n = 1'b1, wr_n = 1'b1, sel_n = 1'b1, rom_wide = 1'b0;
    logic        rom_ce_n, sram_ce_n, mem_oe_n, mem_we_n, drive_lo, drive_hi;
    logic        io_malformed, io_wr_pulse;
    logic [19:0] dev_addr;
    logic [7:0]  io_wr_port;
    logic [15:0] io_wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    cart_bus_decoder dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .mem_sel(mem_sel), .rd_n(rd_n), .wr_n(wr_n), .sel_n(sel_n),
        .rom_wide(rom_wide), .rom_ce_n(rom_ce_n), .sram_ce_n(sram_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .dev_addr(dev_addr),
        .drive_lo(drive_lo), .drive_hi(drive_hi), .io_malformed(io_malformed),
        .io_wr_pulse(io_wr_pulse), .io_wr_port(io_wr_port), .io_wr_data(io_wr_data)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (addr %0h)", req, act, exp, bus_addr);
        end
    endtask

    // Compare every combinational output against the arithmetic model.
    task automatic check_decode();
        logic [3:0] seg;
        logic [7:0] port;
        bit en, sram, rom, claim, wide, bad, e_lo;
        logic [19:0] e_addr;
        seg  = bus_addr[19:16];
        port = bus_addr[7:0];
        en   = !sel_n;
        sram = mem_sel && seg == 4'd1;
        rom  = mem_sel && seg >= 4'd2;
        bad  = !mem_sel && (bus_addr[15:8] != 8'h00 || seg != port[7:4]);
        claim = sram || rom || (!mem_sel && !bad && port >= 8'hC0);
        wide = rom && rom_wide;
        e_addr = wide ? {bus_addr[19:1], 1'b0} : bus_addr;
        e_lo = en && !rd_n && claim;
        chk(rom_ce_n == !(en && rom), "R1 rom_ce_n", rom_ce_n, !(en && rom));
        chk(sram_ce_n == !(en && sram), "R1 sram_ce_n", sram_ce_n, !(en && sram));
        chk(mem_oe_n == !(en && (sram || rom) && !rd_n), "R2 mem_oe_n", mem_oe_n,
            !(en && (sram || rom) && !rd_n));
        chk(mem_we_n == !(en && (sram || rom) && !wr_n), "R2 mem_we_n", mem_we_n,
            !(en && (sram || rom) && !wr_n));
        chk(drive_hi == (e_lo && wide), "R3 drive_hi", drive_hi, e_lo && wide);
        chk(dev_addr == e_addr, "R4 dev_addr", dev_addr, e_addr);
        chk(drive_lo == e_lo, "R7 drive_lo", drive_lo, e_lo);
        chk(io_malformed == (en && bad), "R6 io_malformed", io_malformed, en && bad);
    endtask

    // One asynchronous I/O write; count pulses and check what was captured.
    task automatic io_write(input logic [19:0] a, input logic [15:0] d, input bit sel,
                            input int exp_pulses, input string req);
        int pulses = 0;
        logic [7:0]  got_port = '0;
        logic [15:0] got_data = '0;
        @(negedge clk);
        mem_sel = 1'b0; bus_addr = a; bus_data = d; sel_n = !sel;
        @(negedge clk);
        wr_n = 1'b0;
        repeat (5) @(negedge clk);
        wr_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (io_wr_pulse) begin
                pulses++;
                got_port = io_wr_port;
                got_data = io_wr_data;
            end
        end
        chk(pulses == exp_pulses, {req, " pulse count"}, pulses, exp_pulses);
        if (exp_pulses == 1) begin
            chk(got_port == a[7:0], "R8 port", got_port, a[7:0]);
            chk(got_data == d, "R8 data", got_data, d);
        end
        sel_n = 1'b1;
        bus_data = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(io_wr_pulse == 1'b0, "R10 pulse", io_wr_pulse, 0);
        chk(io_wr_port == 8'h00, "R10 port", io_wr_port, 0);
        chk(io_wr_data == 16'h0000, "R10 data", io_wr_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1-R4, R7: memory sweep
        for (int seg = 0; seg < 16; seg++)
            for (int w = 0; w < 2; w++)
                for (int a0 = 0; a0 < 2; a0++)
                    for (int st = 0; st < 3; st++)
                        for (int s = 0; s < 2; s++) begin
                            @(negedge clk);
                            mem_sel = 1'b1; rom_wide = w[0];
                            bus_addr = {seg[3:0], 16'h5A5A ^ 16'(seg * 16'h1111)};
                            bus_addr[0] = a0[0];
                            rd_n = (st != 1); wr_n = (st != 2); sel_n = s[0];
                            #1 check_decode();
                        end

        // R5, R6: I/O port sweep with good and corrupted mirrors
        for (int p = 0; p < 256; p++)
            for (int m = 0; m < 3; m++)
                for (int r = 0; r < 2; r++) begin
                    @(negedge clk);
                    mem_sel = 1'b0; rom_wide = 1'b1; sel_n = (p % 7 == 3);
                    rd_n = r[0]; wr_n = 1'b1;
                    bus_addr = {p[7:4], 8'h00, p[7:0]};
                    if (m == 1) bus_addr[15:8] = 8'h01 << (p % 8);
                    if (m == 2) bus_addr[19:16] = p[7:4] ^ 4'h8;
                    #1 check_decode();
                    chk(rom_ce_n && sram_ce_n && mem_oe_n, "R5 no mem on io",
                        {rom_ce_n, sram_ce_n, mem_oe_n}, 3'b111);
                end
        @(negedge clk);
        rd_n = 1'b1; sel_n = 1'b1;

        // R8, R9: synchronized port writes
        io_write({4'hC, 8'h00, 8'hC0}, 16'hBEEF, 1'b1, 1, "R8 port C0");
        io_write({4'hF, 8'h00, 8'hFF}, 16'h1234, 1'b1, 1, "R8 port FF");
        io_write({4'hD, 8'h00, 8'hD5}, 16'hA55A, 1'b1, 1, "R8 port D5");
        io_write({4'hB, 8'h00, 8'hBF}, 16'h7777, 1'b1, 0, "R9 port BF");
        io_write({4'hC, 8'h10, 8'hC4}, 16'h6666, 1'b1, 0, "R9 malformed");
        io_write({4'hE, 8'h00, 8'hE1}, 16'h5555, 1'b0, 0, "R9 deselected");
        // R9: rejected writes leave the last captured values in place
        chk(io_wr_port == 8'hD5, "R9 port kept", io_wr_port, 8'hD5);
        chk(io_wr_data == 16'hA55A, "R9 data kept", io_wr_data, 16'hA55A);

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule